// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit with Carry

This block applies one of seven shift or rotate operations to an 8-bit or 16-bit operand. It does this one single-bit step per clock, for as many steps as the count input asks. Each step updates a carry bit. After the last step, the carry holds the final bit that left the operand, or that was copied out of it. A caller presents the operand, the count, the width, the operation code and a carry-in together with a one-cycle `start` pulse. It then reads the result and the carry-out while `done` is high.

The unit works with one operation in flight. A new `start` is accepted when the unit is idle, or in the same cycle that `done` is high. This lets a caller chain operations back to back. The result and carry registers keep their values after completion until the next accepted start.

Top module: `srShiftRotate`

## Requirements
- R1: With `wideMode`=0 the active width is 8 bits and the top bit is bit 7. Result bits 15..8 are zero from load onward, and any operand bits above bit 7 are discarded at load. With `wideMode`=1 the active width is 16 bits and the top bit is bit 15.
- R2: `opSel`=0 (rotate left). On each step, the top bit moves to bit 0 and is also copied into carry.
- R3: `opSel`=1 (rotate left through carry). On each step, the old carry enters bit 0 and the old top bit becomes the carry.
- R4: `opSel`=2 (rotate right) moves bit 0 into the top bit on each step. `opSel`=3 (rotate right through carry) moves the old carry into the top bit on each step. For both, carry takes the old bit 0.
- R5: `opSel`=4 (arithmetic shift right). On each step the top bit is kept, the other bits move down by one, and carry takes the old bit 0.
- R6: `opSel`=5 (shift left) puts the old top bit into carry and fills bit 0 with zero. `opSel`=6 (shift right) puts the old bit 0 into carry and fills the top bit with zero.
- R7: A start accepted at clock edge E with count N applies N steps, one on each of edges E+1..E+N. `done` is high for exactly one cycle, between edges E+N and E+N+1, and `busy` is high from E until `done` ends.
- R8: A count of zero gives `done` in the cycle after the start edge. The result equals the (width-masked) operand and the carry equals `carryIn`.
- R9: A `start` raised while `busy` is high and `done` is low is ignored. The running operation's result, carry and timing are unaffected.
- R10: `opSel`=7 is a hold code. Every step leaves the operand and the carry unchanged.
- R11: After reset, `resultOut`, `carryOut`, `busy` and `done` are all zero. While idle with no start, `resultOut` and `carryOut` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and begin an operation |
| operandIn | input | 16 | Operand to shift or rotate |
| countIn | input | 5 | Number of single-bit steps |
| wideMode | input | 1 | 1 selects 16-bit width, 0 selects 8-bit |
| opSel | input | 3 | Operation code (0..7, see R2..R6, R10) |
| carryIn | input | 1 | Initial carry value |
| resultOut | output | 16 | Current operand value |
| carryOut | output | 1 | Current carry value |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | All steps applied; outputs are final |

## Verification
Two events can fall in the same cycle: the completion of one operation and the acceptance of the next. When `done` is high and `start` arrives in that same cycle, the finishing result must still be readable, and the new operands must load on that edge without losing a step. The bench provokes this by returning to the driver as soon as `done` is seen, and issuing the next start in that cycle. Each scoreboard item carries its own expected completion cycle, so a lost or extra step shows up as a miscompare of timing or of value.

// File: rtl/srPkg.sv
package srPkg;

  typedef enum logic [2:0] {
    OP_ROL  = 3'd0,
    OP_ROLC = 3'd1,
    OP_ROR  = 3'd2,
    OP_RORC = 3'd3,
    OP_SAR  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_HOLD = 3'd7
  } srOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } srStrobe_t;

endpackage

// File: rtl/srControl.sv
module srControl
  import srPkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] countIn,
  output srStrobe_t        strobe,
  output logic             busy,
  output logic             done
);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_e;

  ctlState_e        state;
  logic [CNT_W-1:0] stepsLeft;
  logic             accept;

  assign done   = (state == ST_RUN) && (stepsLeft == '0);
  assign busy   = (state == ST_RUN);
  assign accept = start && ((state == ST_IDLE) || done);

  assign strobe.load = accept;
  assign strobe.step = (state == ST_RUN) && (stepsLeft != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepsLeft <= '0;
    end else if (accept) begin
      state     <= ST_RUN;
      stepsLeft <= countIn;
    end else if (done) begin
      state     <= ST_IDLE;
    end else if (state == ST_RUN) begin
      stepsLeft <= stepsLeft - 1'b1;
    end
  end

endmodule

// File: rtl/srDatapath.sv
module srDatapath
  import srPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  srStrobe_t         strobe,
  input  logic [DATA_W-1:0] operandIn,
  input  logic              wideIn,
  input  logic [2:0]        opIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              carryOut,
  output logic              wideCur
);

  localparam int PAD_W = DATA_W - NARROW_W;
  localparam logic [DATA_W-1:0] NARROW_MASK = {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] dataQ;
  logic              carryQ;
  logic              wideQ;
  srOp_e             opQ;

  logic [DATA_W-1:0] loadMask;
  logic [DATA_W-1:0] stepMask;
  logic              topBit;
  logic              leftFill;
  logic              rightFill;
  logic              isLeft;
  logic [DATA_W-1:0] leftPath;
  logic [DATA_W-1:0] rightPath;
  logic [DATA_W-1:0] nextData;
  logic              nextCarry;

  assign loadMask = wideIn ? '1 : NARROW_MASK;
  assign stepMask = wideQ  ? '1 : NARROW_MASK;
  assign topBit   = wideQ ? dataQ[DATA_W-1] : dataQ[NARROW_W-1];

  always_comb begin
    leftFill  = 1'b0;
    rightFill = 1'b0;
    isLeft    = 1'b0;
    unique case (opQ)
      OP_ROL:  begin isLeft = 1'b1; leftFill = topBit; end
      OP_ROLC: begin isLeft = 1'b1; leftFill = carryQ; end
      OP_SHL:  begin isLeft = 1'b1; end
      OP_ROR:  rightFill = dataQ[0];
      OP_RORC: rightFill = carryQ;
      OP_SAR:  rightFill = topBit;
      default: rightFill = 1'b0;
    endcase
  end

  assign leftPath = {dataQ[DATA_W-2:0], leftFill} & stepMask;

  // right path: the fill lands on bit DATA_W-1 or NARROW_W-1 depending on width
  for (genvar i = 0; i < DATA_W; i++) begin : g_rbit
    if (i == DATA_W-1) begin : g_top
      assign rightPath[i] = wideQ ? rightFill : 1'b0;
    end else if (i == NARROW_W-1) begin : g_narrowTop
      assign rightPath[i] = wideQ ? dataQ[i+1] : rightFill;
    end else begin : g_mid
      assign rightPath[i] = dataQ[i+1];
    end
  end

  always_comb begin
    if (opQ == OP_HOLD) begin
      nextData  = dataQ;
      nextCarry = carryQ;
    end else if (isLeft) begin
      nextData  = leftPath;
      nextCarry = topBit;
    end else begin
      nextData  = rightPath;
      nextCarry = dataQ[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      carryQ <= 1'b0;
      wideQ  <= 1'b0;
      opQ    <= OP_HOLD;
    end else if (strobe.load) begin
      dataQ  <= operandIn & loadMask;
      carryQ <= carryIn;
      wideQ  <= wideIn;
      opQ    <= srOp_e'(opIn);
    end else if (strobe.step) begin
      dataQ  <= nextData;
      carryQ <= nextCarry;
    end
  end

  assign dataOut  = dataQ;
  assign carryOut = carryQ;
  assign wideCur  = wideQ;

endmodule

// File: rtl/srShiftRotate.sv
module srShiftRotate
  import srPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic              wideMode,
  input  logic [2:0]        opSel,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut,
  output logic              busy,
  output logic              done
);

  srStrobe_t strobe;
  logic      wideCur;

  srControl #(.CNT_W(CNT_W)) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .countIn (countIn),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  srDatapath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .operandIn (operandIn),
    .wideIn    (wideMode),
    .opIn      (opSel),
    .carryIn   (carryIn),
    .dataOut   (resultOut),
    .carryOut  (carryOut),
    .wideCur   (wideCur)
  );

endmodule

// File: rtl/srCheck.sv
module srCheck #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [CNT_W-1:0]  countIn,
  input logic [DATA_W-1:0] resultOut,
  input logic              carryOut,
  input logic              busy,
  input logic              done,
  input logic              wideCur
);

  logic             accepted;
  logic [CNT_W-1:0] chkLeft;

  assign accepted = start && (!busy || done);

  // independent step counter for the window check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        chkLeft <= '0;
    else if (accepted)                chkLeft <= countIn;
    else if (busy && chkLeft != '0)   chkLeft <= chkLeft - 1'b1;
  end

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> busy);

  assert_done_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (chkLeft == '0));

  assert_done_due_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && chkLeft == '0) |-> done);

  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !busy);

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && countIn == '0) |=> done);

  assert_narrow_upper_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !wideCur) |-> (resultOut[DATA_W-1:NARROW_W] == '0));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(resultOut) && $stable(carryOut)));

endmodule

bind srShiftRotate srCheck #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .countIn   (countIn),
  .resultOut (resultOut),
  .carryOut  (carryOut),
  .busy      (busy),
  .done      (done),
  .wideCur   (wideCur)
);

// File: tb/srShiftRotate_tb_top.sv
`timescale 1ns/1ps
module srShiftRotate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] operandIn = '0;
  logic [4:0]  countIn = '0;
  logic        wideMode = 1'b0;
  logic [2:0]  opSel = '0;
  logic        carryIn = 1'b0;
  logic [15:0] resultOut;
  logic        carryOut;
  logic        busy;
  logic        done;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  logic [15:0] lastRes = '0;
  logic        lastCarry = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct {
    logic [15:0] res;
    logic        cy;
    int          dueCyc;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  srShiftRotate dut_i (
    .clk(clk), .rstN(rstN), .start(start), .operandIn(operandIn),
    .countIn(countIn), .wideMode(wideMode), .opSel(opSel), .carryIn(carryIn),
    .resultOut(resultOut), .carryOut(carryOut), .busy(busy), .done(done)
  );

  function automatic logic [16:0] modelRun(logic [15:0] d0, int n, bit w, int op, bit c0);
    logic [15:0] d;
    logic [15:0] m;
    bit c;
    bit top;
    bit b0;
    int tp;
    m  = w ? 16'hFFFF : 16'h00FF;
    tp = w ? 15 : 7;
    d  = d0 & m;
    c  = c0;
    for (int k = 0; k < n; k++) begin
      top = d[tp];
      b0  = d[0];
      case (op)
        0: begin d = (d << 1) | 16'(top); c = top; end
        1: begin d = (d << 1) | 16'(c);   c = top; end
        2: begin d = (d >> 1) | (16'(b0) << tp); c = b0; end
        3: begin d = (d >> 1) | (16'(c)  << tp); c = b0; end
        4: begin d = (d >> 1) | (16'(top) << tp); c = b0; end
        5: begin d = d << 1; c = top; end
        6: begin d = d >> 1; c = b0; end
        default: ;
      endcase
      d = d & m;
    end
    return {c, d};
  endfunction

  function automatic string tagFor(int op, int n, bit w);
    string t;
    case (op)
      0: t = "R2";
      1: t = "R3";
      2, 3: t = "R4";
      4: t = "R5";
      5, 6: t = "R6";
      default: t = "R10";
    endcase
    if (n == 0) t = {t, " R8"};
    if (!w) t = {t, " R1"};
    return t;
  endfunction

  function automatic logic [15:0] nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  task automatic checkVal(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // driver: call at a falling edge; pushes the expected item
  task automatic issue(logic [15:0] d, int n, bit w, int op, bit c);
    expItem_t it;
    logic [16:0] r;
    r = modelRun(d, n, w, op, c);
    it.res = r[15:0];
    it.cy = r[16];
    it.dueCyc = cyc + 1 + n;
    it.tag = tagFor(op, n, w);
    scoreQ.push_back(it);
    operandIn = d; countIn = 5'(n); wideMode = w; opSel = 3'(op); carryIn = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // returns at the falling edge where a new start may be accepted
  task automatic waitReady();
    while (busy && !done) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (scoreQ.size() == 0) begin
        checkVal("R7 unexpected done", 1, 0);
      end else begin
        expItem_t it;
        it = scoreQ.pop_front();
        checkVal({it.tag, " result"}, int'(resultOut), int'(it.res));
        checkVal({it.tag, " carry"}, int'(carryOut), int'(it.cy));
        checkVal({it.tag, " R7 done cycle"}, cyc, it.dueCyc);
        lastRes = resultOut;
        lastCarry = carryOut;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    checkVal("R11 reset result", int'(resultOut), 0);
    checkVal("R11 reset carry", int'(carryOut), 0);
    checkVal("R11 reset busy", int'(busy), 0);
    checkVal("R11 reset done", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corner cases
    issue(16'h0081, 1, 1'b0, 0, 1'b0);   // R2 byte: 0x03, c=1
    waitReady();
    issue(16'h8001, 1, 1'b1, 0, 1'b0);   // R2 word: 0x0003, c=1
    waitReady();
    issue(16'h0080, 1, 1'b0, 1, 1'b0);   // R3: 0x00, c=1
    waitReady();
    issue(16'h0001, 1, 1'b0, 3, 1'b1);   // R4 rorc: 0x80, c=1
    waitReady();
    issue(16'h8000, 3, 1'b1, 4, 1'b0);   // R5 word sar
    waitReady();
    issue(16'hFF84, 2, 1'b0, 4, 1'b1);   // R5 byte, upper bits dropped R1
    waitReady();
    issue(16'h00C0, 2, 1'b0, 5, 1'b0);   // R6 shl
    waitReady();
    issue(16'h0003, 2, 1'b1, 6, 1'b0);   // R6 shr
    waitReady();
    issue(16'h1234, 0, 1'b1, 2, 1'b1);   // R8 zero count
    waitReady();
    issue(16'hABCD, 9, 1'b1, 7, 1'b1);   // R10 hold code
    waitReady();
    issue(16'h0055, 31, 1'b0, 1, 1'b1);  // R3 maximum count

    // R9: start during a run is ignored
    waitReady();
    @(negedge clk); @(negedge clk);
    issue(16'h9A5C, 12, 1'b1, 3, 1'b0);
    @(negedge clk); @(negedge clk);
    operandIn = 16'hFFFF; countIn = 5'd1; opSel = 3'd5; wideMode = 1'b0; carryIn = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitReady();

    // R11: outputs hold while idle after completion
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      checkVal("R11 idle hold result", int'(resultOut), int'(lastRes));
      checkVal("R11 idle hold carry", int'(carryOut), int'(lastCarry));
      @(negedge clk);
    end

    // sweep: every op, both widths, mixed counts; starts coincide with done
    for (int op = 0; op < 8; op++) begin
      for (int w = 0; w < 2; w++) begin
        for (int j = 0; j < 4; j++) begin
          logic [15:0] d;
          int n;
          d = nextRand();
          n = (j == 0) ? 0 : ((j == 3) ? 17 : int'(nextRand() % 16));
          waitReady();
          issue(d, n, bit'(w), op, d[3]);
        end
      end
      waitReady();
      @(negedge clk);
    end

    waitReady();
    @(negedge clk); @(negedge clk);
    checkVal("R7 scoreboard drained", scoreQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule